// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading translation entries from memory. A walk begins at an entry in a context table, picked by a table pointer and a context number. It then descends through up to three levels of tables. At each level, the two low bits of the entry decide what happens next: the walk moves to the next table, stops on a large or small page, or ends with a fault.

On a successful walk the block sets the accessed mark in the final entry. On a write it also sets the modified mark. It writes the entry back only when one of these marks actually changed. A caller starts a walk with a one-cycle strobe. It watches `busy`, and then takes the result during the single cycle in which `done` is high.

Memory is reached through a plain request/acknowledge port that carries one 32-bit word per transaction. A response may arrive after any number of cycles. In physical mode no tables are read at all. Instruction fetches in boot mode are steered into a fixed boot ROM window.

Top module: `ptw_walker`

## Requirements
- R1: The first read of a translated walk goes to address `{ctx_ptr, 4'b0} + ctx_num*4`.
- R2: Entry bits [1:0] give the entry kind: 0 invalid, 1 pointer, 2 leaf, 3 reserved. A pointer's next table base is entry bits [31:2] followed by six zero bits.
- R3: The next read goes to the table base plus 4 times an index. The index is virtual bits [31:24] for the first level below the context table, [23:18] for the second and [17:12] for the third.
- R4: A leaf found after one, two or three descents gives `page_size` 2 (16 MB), 1 (256 KB) or 0 (4 KB). `paddr` is `{entry[31:8], 12'b0}` plus the virtual address bits below the page size. `perm` is entry bits [4:2].
- R5: An invalid entry faults with `fault_type` 1. A reserved entry, a pointer in a third-level table, or a leaf in the context table faults with `fault_type` 4. `fault_level` is the number of descents made before the faulting entry was read.
- R6: A leaf found directly in the context table is a fault with type 4 and level 0.
- R7: On success, entry bit 5 (accessed) is set, and bit 6 (modified) is set as well for a write. The entry is written back to the address it was read from only if its value changed.
- R8: In physical mode no memory is read. A fetch with `boot_mode` high gives `PROM_BASE | vaddr[18:0]`. Every other access gives the virtual address unchanged. Both cases finish with `done` one cycle after the strobe.
- R9: `busy` is high from the cycle after a translated strobe until `done`. `done` lasts one cycle. A strobe while busy is ignored. `mem_req` is never high while idle.
- R10: A memory request holds its address and direction until acknowledged, for any latency. A bus error on a table read faults with `fault_type` 4 at the current level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle start strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_phys | input | 1 | Physical mode, no translation |
| boot_mode | input | 1 | Redirect physical fetches to boot ROM |
| ctx_ptr | input | 32 | Context table pointer |
| ctx_num | input | CTX_W | Context number |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid, one cycle |
| fault | output | 1 | Walk ended in a fault |
| fault_type | output | 3 | 1 invalid, 4 other |
| fault_level | output | 2 | Descents made before the fault |
| paddr | output | 36 | Physical address |
| page_size | output | 2 | 0 4 KB, 1 256 KB, 2 16 MB |
| perm | output | 3 | Raw permission field of the leaf |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Pending request is a write |
| mem_addr | output | 36 | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request complete |
| mem_err | input | 1 | Bus error, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The bench aims at the edges of the entry-kind decision. These are a leaf in the context table, a pointer in the last table, a reserved entry at the middle level, and a bus error on a middle-level read. A decoder that mixed up levels would report the wrong `fault_level` or keep descending, which shows up as an unexpected memory read.

Write-back is checked over repeated reads and writes to one page. A design that always wrote back, or never set the modified mark, produces an extra or a missing write. Large-page offsets and a strobe injected in the middle of a walk are also covered. These expose offset masks cut at the wrong bit, and a walker that restarts partway through a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W    = 32;
    localparam int PA_W    = 36;
    localparam int ENT_W   = 32;
    localparam int ACC_BIT = 5;
    localparam int MOD_BIT = 6;

    localparam logic [2:0] FT_INVALID = 3'd1;
    localparam logic [2:0] FT_OTHER   = 3'd4;

    typedef enum logic [1:0] {
        ET_INVALID  = 2'd0,
        ET_POINTER  = 2'd1,
        ET_LEAF     = 2'd2,
        ET_RESERVED = 2'd3
    } ent_kind_e;

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_256K = 2'd1,
        PG_16M  = 2'd2
    } pg_size_e;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_READ  = 2'd1,
        WS_WBACK = 2'd2
    } walk_st_e;

    typedef enum logic [1:0] {
        DA_DESCEND = 2'd0,
        DA_LEAF    = 2'd1,
        DA_FAULT   = 2'd2
    } dec_act_e;

    typedef struct packed {
        walk_st_e          st;
        logic [1:0]        level;
        logic [VA_W-1:0]   vaddr;
        logic              write;
        logic [PA_W-1:0]   addr;
        logic [ENT_W-1:0]  entry;
        logic              done;
        logic              fault;
        logic [2:0]        ftype;
        logic [1:0]        flevel;
        logic [PA_W-1:0]   pa;
        pg_size_e          psize;
        logic [2:0]        perm;
    } walk_state_t;

endpackage

// File: rtl/ptw_index.sv
module ptw_index
    import ptw_pkg::*;
(
    input  logic [1:0]      level,
    input  logic [PA_W-1:0] base,
    input  logic [19:0]     vpn,
    output logic [PA_W-1:0] addr
);

    logic [7:0] idx;

    always_comb begin
        case (level)
            2'd1:    idx = vpn[19:12];
            2'd2:    idx = {2'b00, vpn[11:6]};
            default: idx = {2'b00, vpn[5:0]};
        endcase
        addr = base + {{(PA_W-10){1'b0}}, idx, 2'b00};
    end

endmodule

// File: rtl/ptw_decode.sv
module ptw_decode
    import ptw_pkg::*;
(
    input  logic [ENT_W-1:0] entry,
    input  logic [1:0]       level,
    input  logic             write,
    input  logic [23:0]      voff,
    output dec_act_e         act,
    output logic [2:0]       ftype,
    output logic [PA_W-1:0]  next_base,
    output pg_size_e         psize,
    output logic [PA_W-1:0]  leaf_pa,
    output logic [ENT_W-1:0] upd_entry,
    output logic             need_wb
);

    ent_kind_e       kind;
    logic [PA_W-1:0] off;

    always_comb begin
        kind  = ent_kind_e'(entry[1:0]);
        act   = DA_FAULT;
        ftype = FT_OTHER;
        case (kind)
            ET_INVALID: ftype = FT_INVALID;
            ET_POINTER: if (level != 2'd3) act = DA_DESCEND;
            ET_LEAF:    if (level != 2'd0) act = DA_LEAF;
            default:    ;
        endcase

        case (level)
            2'd1:    psize = PG_16M;
            2'd2:    psize = PG_256K;
            default: psize = PG_4K;
        endcase

        case (psize)
            PG_16M:  off = {12'b0, voff};
            PG_256K: off = {18'b0, voff[17:0]};
            default: off = {24'b0, voff[11:0]};
        endcase

        next_base = {entry[31:2], 6'b0};
        leaf_pa   = {entry[31:8], 12'b0} + off;

        upd_entry          = entry;
        upd_entry[ACC_BIT] = 1'b1;
        if (write) upd_entry[MOD_BIT] = 1'b1;
        need_wb = (upd_entry != entry);
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int              CTX_W     = 8,
    parameter int              PROM_KEEP = 19,
    parameter logic [PA_W-1:0] PROM_BASE = 36'h0_FF00_0000
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic              req_phys,
    input  logic              boot_mode,
    input  logic [31:0]       ctx_ptr,
    input  logic [CTX_W-1:0]  ctx_num,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [2:0]        fault_type,
    output logic [1:0]        fault_level,
    output logic [PA_W-1:0]   paddr,
    output logic [1:0]        page_size,
    output logic [2:0]        perm,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [ENT_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [ENT_W-1:0]  mem_rdata
);

    localparam walk_state_t RST_STATE = '0;

    walk_state_t r_q, r_d;

    dec_act_e         dec_act;
    logic [2:0]       dec_ftype;
    logic [PA_W-1:0]  dec_next_base;
    pg_size_e         dec_psize;
    logic [PA_W-1:0]  dec_leaf_pa;
    logic [ENT_W-1:0] dec_upd;
    logic             dec_need_wb;
    logic [1:0]       lvl_next;
    logic [PA_W-1:0]  next_addr;
    logic [PA_W-1:0]  ctx_addr;
    logic [PA_W-1:0]  phys_pa;

    assign lvl_next = r_q.level + 2'd1;

    ptw_decode u_decode (
        .entry     (mem_rdata),
        .level     (r_q.level),
        .write     (r_q.write),
        .voff      (r_q.vaddr[23:0]),
        .act       (dec_act),
        .ftype     (dec_ftype),
        .next_base (dec_next_base),
        .psize     (dec_psize),
        .leaf_pa   (dec_leaf_pa),
        .upd_entry (dec_upd),
        .need_wb   (dec_need_wb)
    );

    ptw_index u_index (
        .level (lvl_next),
        .base  (dec_next_base),
        .vpn   (r_q.vaddr[31:12]),
        .addr  (next_addr)
    );

    always_comb begin
        ctx_addr = {ctx_ptr, 4'b0} + {{(PA_W-CTX_W-2){1'b0}}, ctx_num, 2'b00};
        if (req_fetch && boot_mode)
            phys_pa = PROM_BASE | {{(PA_W-PROM_KEEP){1'b0}}, req_vaddr[PROM_KEEP-1:0]};
        else
            phys_pa = {{(PA_W-VA_W){1'b0}}, req_vaddr};
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            WS_IDLE: begin
                if (req_valid) begin
                    r_d.vaddr  = req_vaddr;
                    r_d.write  = req_write;
                    r_d.fault  = 1'b0;
                    r_d.ftype  = 3'd0;
                    r_d.flevel = 2'd0;
                    r_d.perm   = 3'd0;
                    r_d.psize  = PG_4K;
                    r_d.pa     = '0;
                    if (req_phys) begin
                        r_d.pa   = phys_pa;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st    = WS_READ;
                        r_d.level = 2'd0;
                        r_d.addr  = ctx_addr;
                    end
                end
            end
            WS_READ: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        r_d.fault  = 1'b1;
                        r_d.ftype  = FT_OTHER;
                        r_d.flevel = r_q.level;
                        r_d.st     = WS_IDLE;
                        r_d.done   = 1'b1;
                    end else begin
                        case (dec_act)
                            DA_DESCEND: begin
                                r_d.addr  = next_addr;
                                r_d.level = lvl_next;
                            end
                            DA_LEAF: begin
                                r_d.pa    = dec_leaf_pa;
                                r_d.psize = dec_psize;
                                r_d.perm  = mem_rdata[4:2];
                                r_d.entry = dec_upd;
                                if (dec_need_wb) begin
                                    r_d.st = WS_WBACK;
                                end else begin
                                    r_d.st   = WS_IDLE;
                                    r_d.done = 1'b1;
                                end
                            end
                            default: begin
                                r_d.fault  = 1'b1;
                                r_d.ftype  = dec_ftype;
                                r_d.flevel = r_q.level;
                                r_d.st     = WS_IDLE;
                                r_d.done   = 1'b1;
                            end
                        endcase
                    end
                end
            end
            WS_WBACK: begin
                if (mem_ack) begin
                    r_d.st   = WS_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_STATE;
        else        r_q <= r_d;
    end

    assign busy        = (r_q.st != WS_IDLE);
    assign done        = r_q.done;
    assign fault       = r_q.fault;
    assign fault_type  = r_q.ftype;
    assign fault_level = r_q.flevel;
    assign paddr       = r_q.pa;
    assign page_size   = r_q.psize;
    assign perm        = r_q.perm;
    assign mem_req     = (r_q.st == WS_READ) || (r_q.st == WS_WBACK);
    assign mem_we      = (r_q.st == WS_WBACK);
    assign mem_addr    = r_q.addr;
    assign mem_wdata   = r_q.entry;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             fault,
    input logic [2:0]       fault_type,
    input logic [1:0]       page_size,
    input logic             mem_req,
    input logic             mem_we,
    input logic [PA_W-1:0]  mem_addr,
    input logic [ENT_W-1:0] mem_wdata,
    input logic             mem_ack
);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r5_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (fault_type == 3'd1 || fault_type == 3'd4));

    a_r7_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[ACC_BIT]);

    a_r4_size_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (page_size != 2'd3));

endmodule

bind ptw_walker ptw_walker_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .fault_type (fault_type),
    .page_size  (page_size),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack)
);

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
    import ptw_pkg::*;

    localparam logic [35:0] PROM = 36'h0_FF00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0, req_fetch = 1'b0, req_phys = 1'b0;
    logic        boot_mode = 1'b0;
    logic [31:0] ctx_ptr = 32'h0000_1000;
    logic [7:0]  ctx_num = 8'd3;
    logic        busy, done, fault;
    logic [2:0]  fault_type;
    logic [1:0]  fault_level;
    logic [35:0] paddr;
    logic [1:0]  page_size;
    logic [2:0]  perm;
    logic        mem_req, mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    ptw_walker #(.CTX_W(8), .PROM_KEEP(19), .PROM_BASE(PROM)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_fetch(req_fetch), .req_phys(req_phys),
        .boot_mode(boot_mode), .ctx_ptr(ctx_ptr), .ctx_num(ctx_num),
        .busy(busy), .done(done), .fault(fault), .fault_type(fault_type),
        .fault_level(fault_level), .paddr(paddr), .page_size(page_size), .perm(perm),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata)
    );

    logic [31:0] mem [logic [35:0]];
    bit          errset [logic [35:0]];
    logic [35:0] exp_addr_q [$];
    bit          exp_we_q [$];
    logic [31:0] exp_wdata;
    bit          e_fault;
    logic [2:0]  e_ftype;
    logic [1:0]  e_flevel, e_size;
    logic [35:0] e_pa;
    logic [2:0]  e_perm;
    int errors = 0, checks = 0, lat = 0, wait_left = -1, cycles = 0;
    logic [35:0] ea;
    bit          ew;

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [35:0] tbl(input logic [35:0] base, input logic [31:0] va, input int lvl);
        if (lvl == 1)      return base + 36'({va[31:24], 2'b00});
        else if (lvl == 2) return base + 36'({va[23:18], 2'b00});
        else               return base + 36'({va[17:12], 2'b00});
    endfunction

    function automatic logic [35:0] ctxa(input logic [7:0] n);
        return {ctx_ptr, 4'h0} + 36'(n) * 36'd4;
    endfunction

    function automatic logic [31:0] ptr_ent(input logic [35:0] base);
        return {base[35:6], 2'b01};
    endfunction

    function automatic logic [31:0] leaf_ent(input logic [35:0] pa, input logic [2:0] pm, input bit a, input bit m);
        return {pa[35:12], 1'b0, m, a, pm, 2'b10};
    endfunction

    // Behavioural reference walk: fills the expected access queue and result.
    task automatic model_walk(input logic [31:0] va, input bit wr, input bit fe, input bit ph);
        logic [35:0] a;
        logic [31:0] e, ne;
        int bits;
        bit fin;
        e_fault = 0; e_ftype = 0; e_flevel = 0; e_pa = 0; e_size = 0; e_perm = 0;
        if (ph) begin
            e_pa = (fe && boot_mode) ? (PROM | 36'(va[18:0])) : 36'(va);
            return;
        end
        a = ctxa(ctx_num);
        fin = 0;
        for (int l = 0; l < 4; l++) begin
            if (!fin) begin
                exp_addr_q.push_back(a); exp_we_q.push_back(1'b0);
                e = mem.exists(a) ? mem[a] : 32'h0;
                if (errset.exists(a)) begin
                    e_fault = 1; e_ftype = 4; e_flevel = 2'(l); fin = 1;
                end else if (e[1:0] == 2'd0) begin
                    e_fault = 1; e_ftype = 1; e_flevel = 2'(l); fin = 1;
                end else if (e[1:0] == 2'd3 || (e[1:0] == 2'd2 && l == 0) || (e[1:0] == 2'd1 && l == 3)) begin
                    e_fault = 1; e_ftype = 4; e_flevel = 2'(l); fin = 1;
                end else if (e[1:0] == 2'd1) begin
                    a = tbl({e[31:2], 6'b0}, va, l + 1);
                end else begin
                    e_size = (l == 1) ? 2'd2 : (l == 2) ? 2'd1 : 2'd0;
                    bits = (l == 1) ? 24 : (l == 2) ? 18 : 12;
                    e_pa = {e[31:8], 12'h0} + 36'(va & ((32'h1 << bits) - 32'h1));
                    e_perm = e[4:2];
                    ne = e | 32'h20 | (wr ? 32'h40 : 32'h0);
                    if (ne != e) begin
                        exp_addr_q.push_back(a); exp_we_q.push_back(1'b1); exp_wdata = ne;
                    end
                    fin = 1;
                end
            end
        end
    endtask

    // Memory responder with variable latency, driven away from the active edge.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0; wait_left = -1;
        end else if (rst_n && mem_req) begin
            if (wait_left < 0) wait_left = lat;
            if (wait_left == 0) begin
                if (exp_addr_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R9 unexpected access actual=%h expected=none", mem_addr);
                end else begin
                    ea = exp_addr_q.pop_front(); ew = exp_we_q.pop_front();
                    chk("R1 R2 R3", "access address", 64'(mem_addr), 64'(ea));
                    chk("R7", "access direction", 64'(mem_we), 64'(ew));
                end
                if (mem_we) begin
                    chk("R7", "written entry", 64'(mem_wdata), 64'(exp_wdata));
                    mem[mem_addr] = mem_wdata;
                end else begin
                    mem_err = errset.exists(mem_addr);
                    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                end
                mem_ack = 1'b1;
                wait_left = -1;
            end else begin
                wait_left--;
            end
        end
    end

    task automatic walk(input string tag, input logic [31:0] va, input bit wr, input bit fe, input bit ph, input bit poke);
        int n;
        model_walk(va, wr, fe, ph);
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_fetch = fe; req_phys = ph; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
            if (poke && n == 2) begin
                req_valid = 1'b1; req_vaddr = va ^ 32'h0100_0000; req_phys = 1'b0;
            end else begin
                req_valid = 1'b0;
            end
        end
        chk(tag, "done seen", 64'(done), 64'd1);
        chk(tag, "fault flag", 64'(fault), 64'(e_fault));
        if (e_fault) begin
            chk(tag, "fault type", 64'(fault_type), 64'(e_ftype));
            chk(tag, "fault level", 64'(fault_level), 64'(e_flevel));
        end else begin
            chk(tag, "physical address", 64'(paddr), 64'(e_pa));
            if (!ph) begin
                chk(tag, "page size", 64'(page_size), 64'(e_size));
                chk(tag, "perm field", 64'(perm), 64'(e_perm));
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9", "done single cycle", 64'(done), 64'd0);
        @(negedge clk);
        @(negedge clk);
        chk("R9", "idle after walk", 64'(busy), 64'd0);
        chk(tag, "accesses outstanding", 64'(exp_addr_q.size()), 64'd0);
        lat = (lat + 1) % 4;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    localparam logic [31:0] VA_A = 32'h1234_5678;
    localparam logic [31:0] VA_B = 32'h12C4_5ABC;
    localparam logic [31:0] VA_C = 32'h7F12_3456;
    localparam logic [31:0] VA_D = 32'h1280_0000;
    localparam logic [31:0] VA_E = 32'h1234_9000;
    localparam logic [31:0] VA_F = 32'h12FC_0000;

    initial begin
        mem[ctxa(8'd3)] = ptr_ent(36'h2_0000);
        mem[tbl(36'h2_0000, VA_A, 1)] = ptr_ent(36'h3_0000);
        mem[tbl(36'h3_0000, VA_A, 2)] = ptr_ent(36'h4_0000);
        mem[tbl(36'h4_0000, VA_A, 3)] = leaf_ent(36'h0_ABCD_E000, 3'd3, 1'b0, 1'b0);
        mem[tbl(36'h3_0000, VA_B, 2)] = leaf_ent(36'h9_5500_0000, 3'd5, 1'b0, 1'b0);
        mem[tbl(36'h2_0000, VA_C, 1)] = leaf_ent(36'h3_0000_0000, 3'd1, 1'b1, 1'b1);
        mem[tbl(36'h3_0000, VA_D, 2)] = 32'h0000_0003;
        mem[tbl(36'h4_0000, VA_E, 3)] = ptr_ent(36'h5_0000);
        errset[tbl(36'h3_0000, VA_F, 2)] = 1'b1;
        mem[ctxa(8'd5)] = leaf_ent(36'h1_0000_0000, 3'd2, 1'b0, 1'b0);

        repeat (3) @(negedge clk);
        chk("R9", "reset busy", 64'(busy), 64'd0);
        chk("R9", "reset done", 64'(done), 64'd0);
        chk("R9", "reset mem_req", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        walk("R3", VA_A, 1'b0, 1'b0, 1'b0, 1'b0);   // 4 KB leaf, accessed write-back (R7)
        walk("R7", VA_A, 1'b0, 1'b0, 1'b0, 1'b0);   // already accessed: no write
        walk("R7", VA_A, 1'b1, 1'b0, 1'b0, 1'b0);   // store sets modified
        walk("R7", VA_A, 1'b1, 1'b0, 1'b0, 1'b0);   // nothing changes
        walk("R4", VA_B, 1'b0, 1'b0, 1'b0, 1'b0);   // 256 KB leaf
        walk("R4", VA_C, 1'b0, 1'b0, 1'b0, 1'b0);   // 16 MB leaf, no write-back
        walk("R5", 32'h5500_0000, 1'b0, 1'b0, 1'b0, 1'b0); // invalid below context
        walk("R5", VA_D, 1'b0, 1'b0, 1'b0, 1'b0);   // reserved at second level
        walk("R5", VA_E, 1'b0, 1'b0, 1'b0, 1'b0);   // pointer in last table
        walk("R10", VA_F, 1'b0, 1'b0, 1'b0, 1'b0);  // bus error on table read
        ctx_num = 8'd5;
        walk("R6", VA_A, 1'b0, 1'b0, 1'b0, 1'b0);   // leaf in context table
        ctx_num = 8'd6;
        walk("R5", VA_A, 1'b0, 1'b0, 1'b0, 1'b0);   // invalid context entry
        ctx_num = 8'd3;
        boot_mode = 1'b1;
        walk("R8", 32'h89AB_CDEF, 1'b0, 1'b1, 1'b1, 1'b0);
        walk("R8", 32'h89AB_CDEF, 1'b0, 1'b0, 1'b1, 1'b0);
        boot_mode = 1'b0;
        walk("R8", 32'h89AB_CDEF, 1'b0, 1'b1, 1'b1, 1'b0);
        lat = 3;
        walk("R9", VA_B, 1'b0, 1'b0, 1'b0, 1'b1);   // strobe during walk ignored
        lat = 2;
        walk("R10", VA_A, 1'b0, 1'b0, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule